// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Access Sequencer

This block sits between an internal 16-bit data path and a memory built from two 8-bit banks. One bank holds the even byte addresses and the other holds the odd ones. A request carries a segment value, an offset, a size (byte or word), a direction and, for writes, 16 bits of data. The block forms a 20-bit byte address from the segment and the offset. It then drives the word address, the low address bit and an active-low upper-lane enable. Each byte goes to the lane that matches its address.

A byte can come from either half of the internal path, or go to either half, as the request selects. A word at an even address moves in one bank cycle. A word at an odd address is split into two bank cycles. The low byte moves on the upper lane at the first address. The high byte moves on the lower lane at the next address. The two halves are put back together before the result is returned. Words are stored little-endian, so the most significant byte sits at the higher address. Each bank cycle takes two clocks: one clock to issue, one clock to capture. A single-clock `done` pulse closes each request.

Top module: `byte_lane_seq`

## Requirements
- R1: The byte address is `(req_seg * 16 + req_off) mod 2^20`. `mem_waddr` carries its bits 19:1 and `mem_a0` carries bit 0 on the first bank cycle.
- R2: A byte access at an even address drives `mem_a0`=0 and `mem_bhe_n`=1. The byte moves on `mem_wdata`/`mem_rdata` bits 7:0. The combination `mem_a0`=1 with `mem_bhe_n`=1 never appears while `mem_en` is high.
- R3: A byte access at an odd address drives `mem_a0`=1 and `mem_bhe_n`=0. The byte moves on bits 15:8.
- R4: For a byte access with `req_high`=1, the write byte is taken from `req_wdata[15:8]` and the read byte is returned in `rdata[15:8]`. With `req_high`=0, bits 7:0 are used in both cases. The other half of `rdata` reads 0. The other lane's memory byte is left unchanged.
- R5: A word access at an even address uses one bank cycle with `mem_a0`=0 and `mem_bhe_n`=0. `req_wdata[7:0]` goes to the even bank and `req_wdata[15:8]` goes to the odd bank.
- R6: A word access at an odd address uses two bank cycles.
  - First cycle: `mem_a0`=1 and `mem_bhe_n`=0, and the low byte moves on bits 15:8.
  - Second cycle: `mem_waddr` is one greater, `mem_a0`=0 and `mem_bhe_n`=1, and the high byte moves on bits 7:0.
- R7: When the second cycle of an odd-address word starts from byte address FFFFFh, its word address wraps to 0 (byte address 00000h).
- R8: `done` is high for exactly one clock. It rises 2 clocks after the accepting edge for one bank cycle and 4 clocks after it for two. `mem_en` is high for one clock per bank cycle. On reads, `rdata` holds the assembled value while `done` is high.
- R9: `busy` is high from the accepting edge until the edge that raises `done`. Any `req_valid` seen while `busy` is high is ignored and starts no bank cycle.
- R10: After reset, `busy`, `done` and `mem_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_high | input | 1 | Byte uses the high half of the internal path |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within the segment |
| req_wdata | input | 16 | Internal write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled read result |
| mem_en | output | 1 | Bank cycle strobe |
| mem_we | output | 1 | Bank cycle is a write |
| mem_waddr | output | 19 | Byte select within each bank |
| mem_a0 | output | 1 | Low address bit, 0 enables the even bank |
| mem_bhe_n | output | 1 | Active-low odd bank enable |
| mem_wdata | output | 16 | Lane write data |
| mem_rdata | input | 16 | Lane read data, valid the clock after `mem_en` |

## Verification
The assertions check several things on every cycle.
- The two bank enables are never both off during a cycle.
- `done` and `mem_en` are single-clock pulses, and no bank cycle overlaps `done`.
- `busy` rises only from a request.
- Any bank cycle two clocks after another is a valid second half: even, upper lane off, word address one higher, wrapping at the top of the space.

Other behaviour needs the bench's scenarios, because it only shows through the memory's contents and the returned data.
- Lane steering and byte routing.
- Preservation of the untouched lane.
- Ordering of the most significant byte.
- The segment-plus-offset sum.
- Requests ignored while busy.

// File: rtl/byte_lane_seq_pkg.sv
package byte_lane_seq_pkg;

  // Sequencer phases: each bank cycle is an issue clock then a capture clock.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ISS1 = 3'd1,
    ST_CAP1 = 3'd2,
    ST_ISS2 = 3'd3,
    ST_CAP2 = 3'd4
  } seq_state_t;

  localparam int unsigned LANES = 2;

endpackage

// File: rtl/byte_lane_addr.sv
module byte_lane_addr #(
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  parameter int unsigned ADDR_W    = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);

  localparam int unsigned BASE_W = SEG_W + SEG_SHIFT;

  logic [BASE_W-1:0] base_raw;
  logic [ADDR_W-1:0] base_ext;
  logic [ADDR_W-1:0] off_ext;

  assign base_raw = {seg, {SEG_SHIFT{1'b0}}};
  assign base_ext = ADDR_W'(base_raw);
  assign off_ext  = ADDR_W'(off);
  // Sum truncates to ADDR_W bits, so a carry past the top wraps to zero.
  assign phys     = base_ext + off_ext;

endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer #(
  parameter int unsigned BYTE_W = 8
) (
  // write side
  input  logic                w_word,
  input  logic                w_high,
  input  logic                w_odd,
  input  logic                w_phase,
  input  logic [2*BYTE_W-1:0] w_data,
  output logic [2*BYTE_W-1:0] lane_wdata,
  // read side
  input  logic                r_word,
  input  logic                r_high,
  input  logic                r_odd,
  input  logic                r_phase,
  input  logic                r_lane_a0,
  input  logic [2*BYTE_W-1:0] r_prev,
  input  logic [2*BYTE_W-1:0] r_lane_data,
  output logic [2*BYTE_W-1:0] r_next
);

  localparam int unsigned DATA_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] w_byte;
  logic              w_take_hi;
  logic              w_straight;
  logic [BYTE_W-1:0] r_byte;
  logic              r_dest_hi;
  logic              r_straight;

  // Write: split words take the low byte first, then the high byte.
  assign w_take_hi  = w_word ? w_phase : w_high;
  assign w_byte     = w_take_hi ? w_data[DATA_W-1:BYTE_W] : w_data[BYTE_W-1:0];
  assign w_straight = w_word && !w_odd;

  // The lone byte is copied onto both lanes; the bank enables pick the real one.
  always_comb begin
    if (w_straight) begin
      lane_wdata = w_data;
    end else begin
      lane_wdata = {w_byte, w_byte};
    end
  end

  // Read: pull the byte from the lane the cycle enabled, drop it in its half.
  assign r_straight = r_word && !r_odd;
  assign r_byte     = r_lane_a0 ? r_lane_data[DATA_W-1:BYTE_W] : r_lane_data[BYTE_W-1:0];
  assign r_dest_hi  = r_word ? r_phase : r_high;

  always_comb begin
    if (r_straight) begin
      r_next = r_lane_data;
    end else if (r_dest_hi) begin
      r_next = {r_byte, r_prev[BYTE_W-1:0]};
    end else begin
      r_next = {r_prev[DATA_W-1:BYTE_W], r_byte};
    end
  end

endmodule

// File: rtl/byte_lane_ctrl.sv
module byte_lane_ctrl
  import byte_lane_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_word,
  input  logic                req_high,
  input  logic [ADDR_W-1:0]   req_phys,
  input  logic [2*BYTE_W-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [2*BYTE_W-1:0] rdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-2:0]   mem_waddr,
  output logic                mem_a0,
  output logic                mem_bhe_n,
  output logic [2*BYTE_W-1:0] mem_wdata,
  input  logic [2*BYTE_W-1:0] mem_rdata
);

  localparam int unsigned DATA_W  = 2 * BYTE_W;
  localparam int unsigned WADDR_W = ADDR_W - 1;

  seq_state_t         st;
  logic               word_q;
  logic               high_q;
  logic               odd_q;
  logic [WADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rd_q;

  logic               idle;
  logic               split;
  logic [WADDR_W-1:0] waddr_nxt;
  logic [DATA_W-1:0]  lane_wdata;
  logic [DATA_W-1:0]  rd_next;

  assign idle      = (st == ST_IDLE);
  assign busy      = !idle;
  assign split     = word_q && odd_q;
  assign waddr_nxt = waddr_q + WADDR_W'(1);

  byte_lane_steer #(
    .BYTE_W(BYTE_W)
  ) u_steer (
    .w_word     (idle ? req_word  : word_q),
    .w_high     (idle ? req_high  : high_q),
    .w_odd      (idle ? req_phys[0] : odd_q),
    .w_phase    (!idle),
    .w_data     (idle ? req_wdata : wdata_q),
    .lane_wdata (lane_wdata),
    .r_word     (word_q),
    .r_high     (high_q),
    .r_odd      (odd_q),
    .r_phase    (st == ST_CAP2),
    .r_lane_a0  (mem_a0),
    .r_prev     (rd_q),
    .r_lane_data(mem_rdata),
    .r_next     (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      word_q    <= 1'b0;
      high_q    <= 1'b0;
      odd_q     <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
      rd_q      <= '0;
      done      <= 1'b0;
      rdata     <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_a0    <= 1'b0;
      mem_bhe_n <= 1'b1;
      mem_wdata <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            word_q    <= req_word;
            high_q    <= req_high;
            odd_q     <= req_phys[0];
            waddr_q   <= req_phys[ADDR_W-1:1];
            wdata_q   <= req_wdata;
            rd_q      <= '0;
            mem_en    <= 1'b1;
            mem_we    <= req_write;
            mem_waddr <= req_phys[ADDR_W-1:1];
            mem_a0    <= req_phys[0];
            mem_bhe_n <= !(req_word || req_phys[0]);
            mem_wdata <= lane_wdata;
            st        <= ST_ISS1;
          end
        end
        ST_ISS1: begin
          mem_en <= 1'b0;
          st     <= ST_CAP1;
        end
        ST_CAP1: begin
          rd_q <= rd_next;
          if (split) begin
            // second half: next word address, even bank only
            mem_en    <= 1'b1;
            mem_waddr <= waddr_nxt;
            mem_a0    <= 1'b0;
            mem_bhe_n <= 1'b1;
            mem_wdata <= lane_wdata;
            st        <= ST_ISS2;
          end else begin
            rdata <= rd_next;
            done  <= 1'b1;
            st    <= ST_IDLE;
          end
        end
        ST_ISS2: begin
          mem_en <= 1'b0;
          st     <= ST_CAP2;
        end
        ST_CAP2: begin
          rd_q  <= rd_next;
          rdata <= rd_next;
          done  <= 1'b1;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/byte_lane_seq.sv
module byte_lane_seq #(
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BYTE_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_word,
  input  logic                req_high,
  input  logic [SEG_W-1:0]    req_seg,
  input  logic [OFF_W-1:0]    req_off,
  input  logic [2*BYTE_W-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [2*BYTE_W-1:0] rdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-2:0]   mem_waddr,
  output logic                mem_a0,
  output logic                mem_bhe_n,
  output logic [2*BYTE_W-1:0] mem_wdata,
  input  logic [2*BYTE_W-1:0] mem_rdata
);

  logic [ADDR_W-1:0] phys;

  byte_lane_addr #(
    .SEG_W    (SEG_W),
    .OFF_W    (OFF_W),
    .SEG_SHIFT(SEG_SHIFT),
    .ADDR_W   (ADDR_W)
  ) u_addr (
    .seg (req_seg),
    .off (req_off),
    .phys(phys)
  );

  byte_lane_ctrl #(
    .ADDR_W(ADDR_W),
    .BYTE_W(BYTE_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_word (req_word),
    .req_high (req_high),
    .req_phys (phys),
    .req_wdata(req_wdata),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr),
    .mem_a0   (mem_a0),
    .mem_bhe_n(mem_bhe_n),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

endmodule

// File: rtl/byte_lane_seq_chk.sv
module byte_lane_seq_chk #(
  parameter int unsigned WADDR_W = 19
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               busy,
  input logic               done,
  input logic               mem_en,
  input logic               mem_a0,
  input logic               mem_bhe_n,
  input logic [WADDR_W-1:0] mem_waddr
);

  // R10: reset leaves the block idle
  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_en));

  // R2: some bank is always enabled during a cycle
  assert_lane_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_a0) |-> !mem_bhe_n);

  // R8: completion is a single pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: each bank cycle strobe lasts one clock
  assert_en_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en);

  // R8: no bank cycle while completing
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_en);

  // R9: busy only starts from a request
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R6 and R7: a strobe two clocks after another is the even second half,
  // one word further on, wrapping at the top of the space
  assert_split_second_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_en && $past(mem_en, 2)) |->
      (!mem_a0 && mem_bhe_n && (mem_waddr == $past(mem_waddr, 2) + WADDR_W'(1))));

endmodule

bind byte_lane_seq byte_lane_seq_chk #(.WADDR_W(ADDR_W - 1)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .busy     (busy),
  .done     (done),
  .mem_en   (mem_en),
  .mem_a0   (mem_a0),
  .mem_bhe_n(mem_bhe_n),
  .mem_waddr(mem_waddr)
);

// File: tb/byte_lane_seq_bench.sv
module byte_lane_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_word  = 1'b0;
  logic        req_high  = 1'b0;
  logic [15:0] req_seg   = '0;
  logic [15:0] req_off   = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, mem_en, mem_we, mem_a0, mem_bhe_n;
  logic [15:0] rdata, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [18:0] mem_waddr;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  byte_lane_seq u_byte_lane_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_high(req_high), .req_seg(req_seg),
    .req_off(req_off), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_a0(mem_a0), .mem_bhe_n(mem_bhe_n), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // Two-bank memory model, 256 bytes per bank, synchronous read.
  logic [7:0] bank_even [0:255];
  logic [7:0] bank_odd  [0:255];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we && !mem_a0)    bank_even[mem_waddr[7:0]] <= mem_wdata[7:0];
      if (mem_we && !mem_bhe_n) bank_odd[mem_waddr[7:0]]  <= mem_wdata[15:8];
      mem_rdata <= {bank_odd[mem_waddr[7:0]], bank_even[mem_waddr[7:0]]};
    end
  end

  // Bus monitor: records every bank cycle.
  int          mon_cnt = 0;
  logic        mon_a0  [0:3];
  logic        mon_bhe [0:3];
  logic [18:0] mon_wa  [0:3];

  always @(negedge clk) begin
    if (mem_en) begin
      mon_a0[mon_cnt % 4]  <= mem_a0;
      mon_bhe[mon_cnt % 4] <= mem_bhe_n;
      mon_wa[mon_cnt % 4]  <= mem_waddr;
      mon_cnt <= mon_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic        wd;
    logic        hi;
    logic [15:0] seg;
    logic [15:0] off;
    logic [15:0] wdat;
    logic [15:0] exp;
    logic        two;
    logic        a0;
    logic        bhe;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1,1'b1,1'b0,16'h1000,16'h0010,16'hA1B2,16'h0000,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,16'h1000,16'h0010,16'h0000,16'hA1B2,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,16'h1000,16'h0010,16'h0000,16'h00B2,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,16'h1000,16'h0011,16'h0000,16'h00A1,1'b0,1'b1,1'b0},
    '{1'b0,1'b0,1'b1,16'h1000,16'h0011,16'h0000,16'hA100,1'b0,1'b1,1'b0},
    '{1'b0,1'b0,1'b1,16'h1000,16'h0010,16'h0000,16'hB200,1'b0,1'b0,1'b1},
    '{1'b1,1'b0,1'b1,16'h1000,16'h0011,16'h5C77,16'h0000,1'b0,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,16'h1000,16'h0010,16'h0000,16'h5CB2,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,16'h1000,16'h0010,16'h33E4,16'h0000,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,16'h1000,16'h0010,16'h0000,16'h5CE4,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,16'h2000,16'h0041,16'h1234,16'h0000,1'b1,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,16'h2000,16'h0041,16'h0000,16'h1234,1'b1,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,16'h2000,16'h0040,16'h0000,16'h3400,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,16'h2000,16'h0042,16'h0000,16'h0012,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,16'h2000,16'h0042,16'h0000,16'h0012,1'b0,1'b0,1'b1},
    '{1'b1,1'b1,1'b0,16'h1234,16'hFFFE,16'hCAFE,16'h0000,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,16'h2233,16'h000E,16'h0000,16'hCAFE,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,16'hFFFF,16'h0010,16'h7788,16'h0000,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,16'h0000,16'h0000,16'h0000,16'h7788,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,16'hF000,16'hFFFF,16'h9ABC,16'h0000,1'b1,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,16'hF000,16'hFFFF,16'h0000,16'h9ABC,1'b1,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,16'h0000,16'h0000,16'h0000,16'h779A,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,16'hF000,16'hFFFF,16'h0000,16'h00BC,1'b0,1'b1,1'b0}
  };

  // Issue one request and wait for its completion.
  task automatic do_req(input logic wr, input logic wd, input logic hi,
                        input logic [15:0] seg, input logic [15:0] off,
                        input logic [15:0] wdat, output logic [15:0] rd,
                        output int lat, output int base, output int ncyc,
                        output logic done_after);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_high = hi;
    req_seg = seg; req_off = off; req_wdata = wdat;
    base = mon_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd   = rdata;
    ncyc = mon_cnt - base;
    @(negedge clk);
    done_after = done;
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.wd) return v.off[0] ? "R6" : "R5";
    if (v.hi) return "R4";
    return v.off[0] ? "R3" : "R2";
  endfunction

  initial begin
    logic [15:0] rd;
    int lat, base, ncyc;
    logic dafter;
    for (int i = 0; i < 256; i++) begin
      bank_even[i] = 8'h00;
      bank_odd[i]  = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!busy && !done && !mem_en, "R10", {busy, done, mem_en}, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [19:0] ph;
      string tg;
      v  = VECS[i];
      tg = tag_of(v);
      ph = {v.seg, 4'h0} + {4'h0, v.off};
      do_req(v.wr, v.wd, v.hi, v.seg, v.off, v.wdat, rd, lat, base, ncyc, dafter);
      check(lat == (v.two ? 5 : 3), "R8", lat, v.two ? 5 : 3);
      check(dafter == 1'b0, "R8", dafter, 0);
      check(ncyc == (v.two ? 2 : 1), tg, ncyc, v.two ? 2 : 1);
      check(mon_a0[base % 4] == v.a0 && mon_bhe[base % 4] == v.bhe, tg,
            {mon_a0[base % 4], mon_bhe[base % 4]}, {v.a0, v.bhe});
      check(mon_wa[base % 4] == ph[19:1], "R1", mon_wa[base % 4], ph[19:1]);
      if (v.two) begin
        check(mon_a0[(base + 1) % 4] == 1'b0 && mon_bhe[(base + 1) % 4] == 1'b1, "R6",
              {mon_a0[(base + 1) % 4], mon_bhe[(base + 1) % 4]}, 2'b01);
        check(mon_wa[(base + 1) % 4] == ph[19:1] + 19'd1,
              (ph == 20'hFFFFF) ? "R7" : "R6",
              mon_wa[(base + 1) % 4], ph[19:1] + 19'd1);
      end
      if (!v.wr) check(rd == v.exp, tg, rd, v.exp);
    end

    // R9: a request during busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1; req_high = 1'b0;
    req_seg = 16'h3000; req_off = 16'h0020; req_wdata = 16'h1111;
    base = mon_cnt;
    @(negedge clk);
    check(busy == 1'b1, "R9", busy, 1);
    req_off = 16'h0100; req_wdata = 16'hDEAD;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    check(mon_cnt - base == 1, "R9", mon_cnt - base, 1);
    do_req(1'b0, 1'b1, 1'b0, 16'h3000, 16'h0100, 16'h0000, rd, lat, base, ncyc, dafter);
    check(rd == 16'h0000, "R9", rd, 16'h0000);
    do_req(1'b0, 1'b1, 1'b0, 16'h3000, 16'h0020, 16'h0000, rd, lat, base, ncyc, dafter);
    check(rd == 16'h1111, "R9", rd, 16'h1111);

    // R10: reset in the middle of a split access
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1;
    req_seg = 16'h2000; req_off = 16'h0041;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_en, "R10", {busy, done, mem_en}, 0);
    rst = 1'b0;
    @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule